// File: doc/BRIEF.md
# Reference source switchover handshake

This block moves a clock consumer from one reference source to the other. One source is a clean oscillator path and the other is an alternate path derived from a PLL. A command gives the wanted source on `want_alt` and starts with a one-cycle `go` strobe. The block reads the clock mux control word. If the status bit already shows the wanted source, the command finishes at once. If not, the block writes the request bit once and then polls the status bit until it matches or until a bounded number of polls has run out.

The consumer's secondary input gate may be off while the consumer clock is stopped. In that case the block holds a gate override on for as long as the command runs and drops it as soon as the command ends, whether the switch worked or failed. The caller sees `busy` while a command is in progress, a one-cycle `done` at its end, and a sticky `err` when the status never matched.

Top module: `refsel_handshake`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `gate_force` and `ctrl_we` are all low.
- R2: A `go` is accepted only while the block is idle. `busy` rises on the cycle after acceptance and stays high through the single-cycle `done` pulse. It falls on the cycle after `done`. A `go` that arrives while busy changes neither the target nor the timing.
- R3: Bit 0 of `ctrl_rdata` is the mux status, where 1 means the alternate source is active. If it already equals `want_alt` when the command is evaluated, `done` is seen 1 cycle after the accepting edge and `ctrl_we` never pulses.
- R4: If the status differs, `ctrl_we` pulses exactly once. `ctrl_wdata` carries bit 1 (the request bit, 1 = alternate) equal to the wanted source, and every other bit is copied from `ctrl_rdata`.
- R5: Once the request is written, the status is polled once per cycle. If the status follows the request N cycles after the write edge, with N below MAX_POLLS, `done` is seen N+2 cycles after the accepting edge and `err` stays low.
- R6: If the status has not matched after MAX_POLLS polls (default 4095), `done` is seen MAX_POLLS+1 cycles after the accepting edge with `err` high.
- R7: `err` stays set after `done` until the next accepted `go`, which clears it on the accepting edge.
- R8: If `consumer_on` is low when a command is accepted, `gate_force` is high from the cycle after acceptance through the `done` cycle and low from the next cycle. If `consumer_on` is high, `gate_force` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Command strobe |
| want_alt | input | 1 | Wanted source: 1 = alternate, 0 = clean |
| consumer_on | input | 1 | Consumer clock currently running |
| ctrl_rdata | input | CTRL_W | Mux control word readback; bit 0 = status |
| ctrl_wdata | output | CTRL_W | Control word to write; bit 1 = request |
| ctrl_we | output | 1 | Write strobe for `ctrl_wdata` |
| gate_force | output | 1 | Holds the consumer's input gate on |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky switch timeout flag |

## Verification
The assertions check on every cycle that:
- `done` lasts one cycle and returns the block to idle;
- a go that arrives while busy leaves the latched target untouched;
- each command makes at most one write;
- `err` only rises together with `done`;
- the gate override only drops right after `done`;
- a clean completion follows a status that matched the target.

Only the bench's scenarios can show the rest:
- the exact completion latency against the status latency, swept across the timeout boundary;
- that the other control bits are preserved;
- a status that never follows;
- `err` persisting across idle time;
- the gate override's dependence on whether the consumer is running.

// File: rtl/refsel_handshake.sv
module refsel_handshake #(
  parameter int CTRL_W    = 8,
  parameter int MAX_POLLS = 4095
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              want_alt,
  input  logic              consumer_on,
  input  logic [CTRL_W-1:0] ctrl_rdata,
  output logic [CTRL_W-1:0] ctrl_wdata,
  output logic              ctrl_we,
  output logic              gate_force,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam int CW = $clog2(MAX_POLLS + 1);
  localparam logic [CW-1:0] LAST_POLL = CW'(MAX_POLLS - 1);

  typedef enum logic [1:0] {S_IDLE, S_EVAL, S_WAIT, S_DONE} st_t;
  st_t           st;
  logic          want_q;
  logic [CW-1:0] polls;

  wire hit = (ctrl_rdata[0] == want_q);

  assign busy       = (st != S_IDLE);
  assign done       = (st == S_DONE);
  assign ctrl_we    = (st == S_EVAL) && !hit;
  assign ctrl_wdata = {ctrl_rdata[CTRL_W-1:2], want_q, ctrl_rdata[0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      want_q     <= 1'b0;
      polls      <= '0;
      err        <= 1'b0;
      gate_force <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (go) begin
          want_q     <= want_alt;
          err        <= 1'b0;
          gate_force <= !consumer_on;
          st         <= S_EVAL;
        end
        S_EVAL: begin
          polls <= '0;
          st    <= hit ? S_DONE : S_WAIT;
        end
        S_WAIT: begin
          if (hit) st <= S_DONE;
          else if (polls == LAST_POLL) begin
            err <= 1'b1;
            st  <= S_DONE;
          end else polls <= polls + 1'b1;
        end
        default: begin
          gate_force <= 1'b0;
          st         <= S_IDLE;
        end
      endcase
    end
  end

  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  assert_go_ignored_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && go) |=> $stable(want_q));
  assert_one_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> !ctrl_we);
  assert_match_on_success_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> ($past(ctrl_rdata[0]) == want_q));
  assert_err_rises_at_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done);
  assert_gate_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_force) |-> $past(done));
endmodule

// File: tb/refsel_handshake_tb.sv
module refsel_handshake_tb;
  localparam int CTRL_W = 8;
  localparam int MAXP   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0, want_alt = 1'b0, consumer_on = 1'b0;
  logic [CTRL_W-1:0] ctrl_rdata, ctrl_wdata;
  logic ctrl_we, gate_force, busy, done, err;

  always #2 clk = ~clk;

  refsel_handshake #(.CTRL_W(CTRL_W), .MAX_POLLS(MAXP)) u_dut (
    .clk(clk), .rst_n(rst_n), .go(go), .want_alt(want_alt),
    .consumer_on(consumer_on), .ctrl_rdata(ctrl_rdata),
    .ctrl_wdata(ctrl_wdata), .ctrl_we(ctrl_we), .gate_force(gate_force),
    .busy(busy), .done(done), .err(err));

  localparam logic [7:1] HI_INIT = 7'b1010100;
  logic [7:1]  hi;
  logic [31:0] hist;
  int          lat = 0;
  bit          stuck = 0;
  logic        hold = 1'b0;
  int          we_cnt = 0;
  logic        status;

  assign status     = stuck ? hold : (lat == 0 ? hi[1] : hist[lat-1]);
  assign ctrl_rdata = {hi, status};

  always @(posedge clk) begin
    if (!rst_n) begin
      hi   <= HI_INIT;
      hist <= '0;
    end else begin
      hist <= {hist[30:0], hi[1]};
      if (ctrl_we) begin
        hi     <= ctrl_wdata[7:1];
        we_cnt <= we_cnt + 1;
      end
    end
  end

  int nchk = 0, nfail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_cmd(input bit w, input bit on, output int n,
                         output bit gate_mid, output bit err_acc);
    int busy_drop;
    busy_drop = 0;
    @(negedge clk);
    want_alt = w; consumer_on = on; go = 1'b1;
    @(posedge clk);
    @(negedge clk);
    go = 1'b0;
    gate_mid = gate_force;
    err_acc  = err;
    n = 0;
    while (!done && n < 100) begin
      if (!busy) busy_drop++;
      @(posedge clk); n++;
      @(negedge clk);
    end
    chk(busy_drop == 0 && busy, "R2 busy held", busy_drop, 0);
    @(posedge clk); @(negedge clk);
    chk(!busy && !done, "R2 busy/done fall after done", {busy, done}, 0);
    chk(!gate_force, "R8 gate released", gate_force, 0);
  endtask

  initial begin
    bit cur, g, ea, w;
    int n, exp_n, we0;
    cur = 1'b0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({busy, done, err, gate_force, ctrl_we} == 5'b0, "R1 reset",
        {busy, done, err, gate_force, ctrl_we}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int on = 0; on < 2; on++) begin
      we0 = we_cnt;
      run_cmd(cur, on[0], n, g, ea);
      chk(n == 1, "R3 no-change latency", n, 1);
      chk(we_cnt == we0, "R3 no write", we_cnt - we0, 0);
      chk(g == !on[0], "R8 gate on no-change", g, !on[0]);
    end

    for (int N = 0; N <= MAXP + 2; N++) begin
      for (int on = 0; on < 2; on++) begin
        lat = N;
        w = !cur;
        we0 = we_cnt;
        run_cmd(w, on[0], n, g, ea);
        exp_n = (N < MAXP) ? N + 2 : MAXP + 1;
        chk(ea == 1'b0, "R7 err cleared on accept", ea, 0);
        chk(n == exp_n, (N < MAXP) ? "R5 latency" : "R6 timeout latency", n, exp_n);
        chk(err == (N >= MAXP), "R6 err flag", err, N >= MAXP);
        chk(we_cnt - we0 == 1, "R4 single write", we_cnt - we0, 1);
        chk(hi[1] == w, "R4 request bit", hi[1], w);
        chk(hi[7:2] == HI_INIT[7:2], "R4 other bits kept", hi[7:2], HI_INIT[7:2]);
        chk(g == !on[0], "R8 gate during switch", g, !on[0]);
        repeat (40) @(negedge clk);
        chk(err == (N >= MAXP), "R7 err persists idle", err, N >= MAXP);
        cur = w;
      end
    end

    lat = 3; w = !cur;
    @(negedge clk);
    want_alt = w; consumer_on = 1'b1; go = 1'b1;
    @(posedge clk); @(negedge clk);
    go = 1'b0;
    @(negedge clk);
    want_alt = cur; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    n = 2;
    while (!done && n < 100) begin
      @(posedge clk); n++;
      @(negedge clk);
    end
    chk(n == 5, "R2 go while busy timing", n, 5);
    @(negedge clk);
    chk(hi[1] == w && !busy, "R2 go while busy target", hi[1], w);
    repeat (40) @(negedge clk);
    cur = w;

    hold = status; stuck = 1; w = !cur;
    run_cmd(w, 1'b0, n, g, ea);
    chk(n == MAXP + 1, "R6 stuck status timeout", n, MAXP + 1);
    chk(err == 1'b1, "R6 stuck err", err, 1);
    repeat (10) @(negedge clk);
    chk(err == 1'b1, "R7 err held", err, 1);
    stuck = 0;
    repeat (40) @(negedge clk);
    cur = w;
    run_cmd(cur, 1'b1, n, g, ea);
    chk(ea == 1'b0 && err == 1'b0, "R7 err cleared by go", err, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #400000;
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule